// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

A register-mapped mailbox through which a host issues short commands to an embedded service controller and collects the outcome. The host sees a plain 32-bit register bus. Writes commit on a clock edge. Reads are combinational from the address. Through this bus the host loads two pointer words and a four-word outbound payload. It then writes a packed command word, and that write acts as the doorbell. The host learns of completion by polling a status word or by waiting for an interrupt.

The controller side receives a one-cycle service strobe together with the decoded command fields and both pointers. It reads the outbound payload through its own read port and deposits reply words into a four-word inbound buffer. It finishes by pulsing `done_i` with an 8-bit result code. When the finished command asked for an interrupt, a pending flag is set and drives `irq_o` until the host clears it by writing 1 to it.

Top module: `host_cmd_mailbox`

## Requirements
- R1: After reset, every register and buffer word reads 0, `irq_o` is low and `svc_req_o` is low.
- R2: The source pointer (byte offset 0x08), the destination pointer (0x0C) and the outbound words (0x80, 0x84, 0x88, 0x8C) read back what the host wrote. Outbound word k also appears on `ob_rdata_o` when `ob_raddr_i` = k. The source and destination pointers are driven on `svc_src_ptr_o` and `svc_dst_ptr_o`.
- R3: A host write to offset 0x00 while idle is accepted. After the write edge, `svc_req_o` is high for exactly one cycle. `svc_code_o` then carries written bits 7:0, `svc_sub_o` carries bits 15:12 and `svc_len_o` carries bits 20:16. Reading 0x00 returns those bits and bit 8, the interrupt request; every other bit reads 0.
- R4: The status word at 0x04 has bit 0 = busy, bit 1 = error, bit 2 = interrupt pending, and bits 23:16 = error code; all other bits read 0. Busy is set from the edge that accepts a command until the edge that samples `done_i`. While busy, the error flag and the error code read 0.
- R5: A command write while busy is ignored: no new `svc_req_o` pulse, and the command readback and the `svc_*` fields are unchanged.
- R6: On completion, `err_code_i` is latched into status bits 23:16, and the error flag is set exactly when the code is nonzero. Codes 0 to 7 mean, in order: no error, not supported, not serviced, unable to service, invalid, failed, security rejection, unsigned-image rejection. The block passes the code through without interpreting it.
- R7: On completion, status bit 2 and `irq_o` become 1 only if bit 8 of the accepted command was 1; otherwise they stay 0.
- R8: A status write with bit 2 set clears the pending interrupt and `irq_o`. A status write with bit 2 clear leaves them unchanged.
- R9: Controller writes (`ib_we_i`, `ib_waddr_i`, `ib_wdata_i`) made while busy land in inbound word k at 0x90 + 4k, and they stay readable after completion. Accepting a new command zeroes all inbound words. Controller writes made while idle are ignored.
- R10: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Host write enable, committed on the clock edge |
| bus_addr_i | input | 8 | Host byte address |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data for `bus_addr_i` (combinational) |
| svc_req_o | output | 1 | One-cycle service request to the controller |
| svc_code_o | output | 8 | Command code |
| svc_sub_o | output | 4 | Subcommand |
| svc_len_o | output | 5 | Input payload length in bytes |
| svc_src_ptr_o | output | 32 | Source pointer register |
| svc_dst_ptr_o | output | 32 | Destination pointer register |
| ob_raddr_i | input | 2 | Controller read index into the outbound buffer |
| ob_rdata_o | output | 32 | Outbound buffer word at `ob_raddr_i` |
| ib_we_i | input | 1 | Controller write strobe into the inbound buffer |
| ib_waddr_i | input | 2 | Inbound buffer word index |
| ib_wdata_i | input | 32 | Inbound buffer write data |
| done_i | input | 1 | Controller completion strobe |
| err_code_i | input | 8 | Result code sampled with `done_i` |
| irq_o | output | 1 | Completion interrupt to the host |

## Verification
The hardest situation to reach is a second command write that lands during the busy window, because it must leave no trace. The bench sends one deliberately while the emulated controller is still filling the inbound buffer. It then confirms that no strobe fires and that both the readback and the decoded fields are unchanged. The sweep covers all eight result codes, each with and without the interrupt request. Each completion is followed by a write-0 and then a write-1 to the pending flag. Each new command is followed by a read of the inbound words, which must now be zero, so the clear on acceptance is seen at the ports.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 8;
  localparam int unsigned BUF_WORDS = 4;
  localparam int unsigned BUF_IW    = $clog2(BUF_WORDS);
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned SUB_W     = 4;
  localparam int unsigned LEN_W     = 5;

  localparam logic [AW-1:0] OFF_CMD  = 8'h00;
  localparam logic [AW-1:0] OFF_STS  = 8'h04;
  localparam logic [AW-1:0] OFF_SRC  = 8'h08;
  localparam logic [AW-1:0] OFF_DST  = 8'h0C;
  localparam logic [3:0]    PAGE_OB  = 4'h8;
  localparam logic [3:0]    PAGE_IB  = 4'h9;

  // command word field positions
  localparam int unsigned CMD_CODE_LSB = 0;
  localparam int unsigned CMD_IRQ_BIT  = 8;
  localparam int unsigned CMD_SUB_LSB  = 12;
  localparam int unsigned CMD_LEN_LSB  = 16;

  // status word field positions
  localparam int unsigned STS_BUSY_BIT = 0;
  localparam int unsigned STS_ERR_BIT  = 1;
  localparam int unsigned STS_IRQ_BIT  = 2;
  localparam int unsigned STS_CODE_LSB = 16;

  typedef enum logic [CODE_W-1:0] {
    RES_OK          = 8'd0,
    RES_UNSUPPORTED = 8'd1,
    RES_NOT_SERVED  = 8'd2,
    RES_CANNOT      = 8'd3,
    RES_INVALID     = 8'd4,
    RES_FAILED      = 8'd5,
    RES_SECURITY    = 8'd6,
    RES_UNSIGNED    = 8'd7
  } res_code_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [SUB_W-1:0]  sub;
    logic              irq;
    logic [CODE_W-1:0] code;
  } cmd_t;
endpackage

// File: rtl/mbx_word_buf.sv
module mbx_word_buf #(
  parameter int unsigned NWORDS = 4,
  parameter int unsigned DW     = 32,
  localparam int unsigned IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wa_en_i,
  input  logic [IW-1:0] wa_idx_i,
  input  logic [DW-1:0] wa_data_i,
  input  logic          wb_en_i,
  input  logic [IW-1:0] wb_idx_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic [IW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o
);
  logic [DW-1:0] mem_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem_q[g] <= '0;
      else if (clr_i)                                 mem_q[g] <= '0;
      else if (wa_en_i && wa_idx_i == IW'(g))         mem_q[g] <= wa_data_i;
      else if (wb_en_i && wb_idx_i == IW'(g))         mem_q[g] <= wb_data_i;
    end
  end

  assign ra_data_o = mem_q[ra_idx_i];
  assign rb_data_o = mem_q[rb_idx_i];
endmodule

// File: rtl/mbx_cmd_ctrl.sv
module mbx_cmd_ctrl
  import mbx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              sts_we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              done_i,
  input  logic [CODE_W-1:0] err_code_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              req_o,
  output cmd_t              cmd_o,
  output logic [DW-1:0]     cmd_rd_o,
  output logic [DW-1:0]     sts_rd_o,
  output logic              irq_o
);
  cmd_t              cmd_q;
  logic              busy_q, req_q, err_q, irq_q;
  logic [CODE_W-1:0] code_q;
  logic              finish;
  logic              unused_wbits;

  assign accept_o = cmd_we_i && !busy_q;
  assign finish   = busy_q && done_i;
  assign unused_wbits = ^{wdata_i[DW-1:CMD_LEN_LSB+LEN_W],
                          wdata_i[CMD_SUB_LSB-1:CMD_IRQ_BIT+1],
                          wdata_i[STS_IRQ_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (accept_o) begin
        cmd_q.code <= wdata_i[CMD_CODE_LSB +: CODE_W];
        cmd_q.irq  <= wdata_i[CMD_IRQ_BIT];
        cmd_q.sub  <= wdata_i[CMD_SUB_LSB +: SUB_W];
        cmd_q.len  <= wdata_i[CMD_LEN_LSB +: LEN_W];
        busy_q     <= 1'b1;
        req_q      <= 1'b1;
        err_q      <= 1'b0;
        code_q     <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= |err_code_i;
        code_q <= err_code_i;
      end
      // clear first so a same-cycle completion still raises the flag
      if (sts_we_i && wdata_i[STS_IRQ_BIT]) irq_q <= 1'b0;
      if (finish && cmd_q.irq)              irq_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign req_o  = req_q;
  assign cmd_o  = cmd_q;
  assign irq_o  = irq_q;

  always_comb begin
    cmd_rd_o = '0;
    cmd_rd_o[CMD_CODE_LSB +: CODE_W] = cmd_q.code;
    cmd_rd_o[CMD_IRQ_BIT]            = cmd_q.irq;
    cmd_rd_o[CMD_SUB_LSB +: SUB_W]   = cmd_q.sub;
    cmd_rd_o[CMD_LEN_LSB +: LEN_W]   = cmd_q.len;
    sts_rd_o = '0;
    sts_rd_o[STS_BUSY_BIT]            = busy_q;
    sts_rd_o[STS_ERR_BIT]             = err_q;
    sts_rd_o[STS_IRQ_BIT]             = irq_q;
    sts_rd_o[STS_CODE_LSB +: CODE_W]  = code_q;
  end

  assert_req_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_req_with_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> busy_q);
  assert_busy_ends_on_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(done_i));
  assert_ignore_while_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_we_i && !done_i) |=> ($stable(cmd_q) && !req_q));
  assert_err_matches_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q == (code_q != '0)));
  assert_irq_only_when_asked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(finish && cmd_q.irq));
  assert_irq_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && wdata_i[STS_IRQ_BIT] && !finish) |=> !irq_q);
endmodule

// File: rtl/host_cmd_mailbox.sv
module host_cmd_mailbox
  import mbx_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_wr_i,
  input  logic [AW-1:0]         bus_addr_i,
  input  logic [DW-1:0]         bus_wdata_i,
  output logic [DW-1:0]         bus_rdata_o,
  output logic                  svc_req_o,
  output logic [CODE_W-1:0]     svc_code_o,
  output logic [SUB_W-1:0]      svc_sub_o,
  output logic [LEN_W-1:0]      svc_len_o,
  output logic [DW-1:0]         svc_src_ptr_o,
  output logic [DW-1:0]         svc_dst_ptr_o,
  input  logic [BUF_IW-1:0]     ob_raddr_i,
  output logic [DW-1:0]         ob_rdata_o,
  input  logic                  ib_we_i,
  input  logic [BUF_IW-1:0]     ib_waddr_i,
  input  logic [DW-1:0]         ib_wdata_i,
  input  logic                  done_i,
  input  logic [CODE_W-1:0]     err_code_i,
  output logic                  irq_o
);
  logic [AW-1:0]     waddr;
  logic [3:0]        page;
  logic [BUF_IW-1:0] widx;
  logic              cmd_we, sts_we, src_we, dst_we, ob_we;
  logic              accept, busy;
  cmd_t              cmd;
  logic [DW-1:0]     cmd_rd, sts_rd, ob_host_rd, ib_host_rd, ib_unused_rd;
  logic [DW-1:0]     src_q, dst_q;
  logic              unused_addr;

  assign waddr  = {bus_addr_i[AW-1:2], 2'b00};
  assign page   = bus_addr_i[AW-1:AW-4];
  assign widx   = bus_addr_i[2 +: BUF_IW];
  assign unused_addr = ^{bus_addr_i[1:0], ib_unused_rd};

  assign cmd_we = bus_wr_i && waddr == OFF_CMD;
  assign sts_we = bus_wr_i && waddr == OFF_STS;
  assign src_we = bus_wr_i && waddr == OFF_SRC;
  assign dst_we = bus_wr_i && waddr == OFF_DST;
  assign ob_we  = bus_wr_i && page == PAGE_OB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
    end else begin
      if (src_we) src_q <= bus_wdata_i;
      if (dst_we) dst_q <= bus_wdata_i;
    end
  end

  mbx_cmd_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (cmd_we),
    .sts_we_i   (sts_we),
    .wdata_i    (bus_wdata_i),
    .done_i     (done_i),
    .err_code_i (err_code_i),
    .accept_o   (accept),
    .busy_o     (busy),
    .req_o      (svc_req_o),
    .cmd_o      (cmd),
    .cmd_rd_o   (cmd_rd),
    .sts_rd_o   (sts_rd),
    .irq_o      (irq_o)
  );

  mbx_word_buf #(.NWORDS(BUF_WORDS), .DW(DW)) i_ob_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (1'b0),
    .wa_en_i   (ob_we),
    .wa_idx_i  (widx),
    .wa_data_i (bus_wdata_i),
    .wb_en_i   (1'b0),
    .wb_idx_i  ('0),
    .wb_data_i ('0),
    .ra_idx_i  (widx),
    .ra_data_o (ob_host_rd),
    .rb_idx_i  (ob_raddr_i),
    .rb_data_o (ob_rdata_o)
  );

  // inbound: controller writes only while a command is in flight
  mbx_word_buf #(.NWORDS(BUF_WORDS), .DW(DW)) i_ib_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .wa_en_i   (ib_we_i && busy),
    .wa_idx_i  (ib_waddr_i),
    .wa_data_i (ib_wdata_i),
    .wb_en_i   (1'b0),
    .wb_idx_i  ('0),
    .wb_data_i ('0),
    .ra_idx_i  (widx),
    .ra_data_o (ib_host_rd),
    .rb_idx_i  ('0),
    .rb_data_o (ib_unused_rd)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (page == PAGE_OB)       bus_rdata_o = ob_host_rd;
    else if (page == PAGE_IB)  bus_rdata_o = ib_host_rd;
    else begin
      unique case (waddr)
        OFF_CMD: bus_rdata_o = cmd_rd;
        OFF_STS: bus_rdata_o = sts_rd;
        OFF_SRC: bus_rdata_o = src_q;
        OFF_DST: bus_rdata_o = dst_q;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign svc_code_o    = cmd.code;
  assign svc_sub_o     = cmd.sub;
  assign svc_len_o     = cmd.len;
  assign svc_src_ptr_o = src_q;
  assign svc_dst_ptr_o = dst_q;

  assert_ib_idle_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && ib_we_i && !accept) |=> $stable(i_ib_buf.mem_q[0]) || $past(ib_waddr_i) != '0);
  assert_irq_needs_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !busy);
endmodule

// File: tb/test_host_cmd_mailbox.sv
module test_host_cmd_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        svc_req;
  logic [7:0]  svc_code;
  logic [3:0]  svc_sub;
  logic [4:0]  svc_len;
  logic [31:0] svc_src, svc_dst;
  logic [1:0]  ob_raddr = '0;
  logic [31:0] ob_rdata;
  logic        ib_we = 1'b0;
  logic [1:0]  ib_waddr = '0;
  logic [31:0] ib_wdata = '0;
  logic        done = 1'b0;
  logic [7:0]  err_code = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  host_cmd_mailbox i_host_cmd_mailbox (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .svc_req_o(svc_req), .svc_code_o(svc_code), .svc_sub_o(svc_sub), .svc_len_o(svc_len),
    .svc_src_ptr_o(svc_src), .svc_dst_ptr_o(svc_dst),
    .ob_raddr_i(ob_raddr), .ob_rdata_o(ob_rdata),
    .ib_we_i(ib_we), .ib_waddr_i(ib_waddr), .ib_wdata_i(ib_wdata),
    .done_i(done), .err_code_i(err_code), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ctrl_ib(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    ib_we = 1'b1; ib_waddr = idx; ib_wdata = d;
    @(negedge clk);
    ib_we = 1'b0;
  endtask

  task automatic ctrl_done(input logic [7:0] c);
    @(negedge clk);
    done = 1'b1; err_code = c;
    @(negedge clk);
    done = 1'b0; err_code = '0;
  endtask

  function automatic logic [31:0] ib_val(input int n, input int k);
    return 32'hA000_0000 + 32'(n * 16 + k);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    foreach (v[i]) ;
    for (int a = 0; a < 256; a += 4) begin
      rd(8'(a), v);
      chk("R1 reset readback", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 req after reset", {31'b0, svc_req}, 32'h0);

    // R10: unmapped offsets
    rd(8'h10, v); chk("R10 unmapped 0x10", v, 0);
    rd(8'h7C, v); chk("R10 unmapped 0x7C", v, 0);
    rd(8'hA0, v); chk("R10 unmapped 0xA0", v, 0);

    // R9: controller write while idle is ignored
    ctrl_ib(2'd1, 32'hDEAD_BEEF);
    rd(8'h94, v); chk("R9 idle ib write ignored", v, 0);

    for (int n = 0; n < 16; n++) begin
      logic [7:0]  code  = 8'(n % 8);
      logic        want  = n[3];
      logic [3:0]  sub   = 4'(n + 3);
      logic [4:0]  len   = 5'(n + 1);
      logic [7:0]  cc    = 8'h40 + 8'(n);
      logic [31:0] cmdw  = {11'h7FF, len, sub, 3'b111, want, cc};
      logic [31:0] cmdrb = {11'h0, len, sub, 3'b000, want, cc};
      logic [31:0] sts_e;

      // R2: pointers and outbound buffer
      wr(8'h08, 32'h1000_0000 + 32'(n));
      wr(8'h0C, 32'h2000_0000 + 32'(n));
      for (int k = 0; k < 4; k++) wr(8'h80 + 8'(4 * k), 32'h5000_0000 ^ 32'(n << 8) ^ 32'(k));
      rd(8'h08, v); chk("R2 src ptr", v, 32'h1000_0000 + 32'(n));
      rd(8'h0C, v); chk("R2 dst ptr", v, 32'h2000_0000 + 32'(n));
      chk("R2 src out", svc_src, 32'h1000_0000 + 32'(n));
      chk("R2 dst out", svc_dst, 32'h2000_0000 + 32'(n));
      for (int k = 0; k < 4; k++) begin
        rd(8'h80 + 8'(4 * k), v);
        chk("R2 ob host read", v, 32'h5000_0000 ^ 32'(n << 8) ^ 32'(k));
        ob_raddr = 2'(k);
        #1 chk("R2 ob ctrl read", ob_rdata, 32'h5000_0000 ^ 32'(n << 8) ^ 32'(k));
      end

      // R3: trigger
      wr(8'h00, cmdw);
      #1 chk("R3 req pulse", {31'b0, svc_req}, 32'h1);
      chk("R3 code", {24'b0, svc_code}, {24'b0, cc});
      chk("R3 sub", {28'b0, svc_sub}, {28'b0, sub});
      chk("R3 len", {27'b0, svc_len}, {27'b0, len});
      @(negedge clk);
      #1 chk("R3 req one cycle", {31'b0, svc_req}, 32'h0);
      rd(8'h00, v); chk("R3 cmd readback", v, cmdrb);
      rd(8'h04, v); chk("R4 busy status", v, 32'h1);
      // R9: inbound cleared by acceptance
      for (int k = 0; k < 4; k++) begin
        rd(8'h90 + 8'(4 * k), v); chk("R9 ib cleared on accept", v, 0);
      end

      // R5: write during busy ignored
      ctrl_ib(2'd0, ib_val(n, 0));
      wr(8'h00, 32'h0000_F1FF);
      #1 chk("R5 no req while busy", {31'b0, svc_req}, 32'h0);
      rd(8'h00, v); chk("R5 cmd unchanged", v, cmdrb);
      chk("R5 code out unchanged", {24'b0, svc_code}, {24'b0, cc});
      for (int k = 1; k < 4; k++) ctrl_ib(2'(k), ib_val(n, k));
      rd(8'h04, v); chk("R4 still busy", v, 32'h1);

      // R6/R7: completion
      ctrl_done(code);
      sts_e = {8'h0, code, 13'h0, want, (code != 0), 1'b0};
      rd(8'h04, v); chk("R6 status after done", v, sts_e);
      chk("R7 irq line", {31'b0, irq}, {31'b0, want});
      for (int k = 0; k < 4; k++) begin
        rd(8'h90 + 8'(4 * k), v); chk("R9 ib readback", v, ib_val(n, k));
      end
      // R9: idle controller write ignored
      ctrl_ib(2'd2, 32'h0BAD_0BAD);
      rd(8'h98, v); chk("R9 idle write after done", v, ib_val(n, 2));

      // R8: write 0 keeps, write 1 clears
      wr(8'h04, 32'hFFFF_FFFB);
      rd(8'h04, v); chk("R8 write0 no effect", v, sts_e);
      chk("R8 irq kept", {31'b0, irq}, {31'b0, want});
      wr(8'h04, 32'h0000_0004);
      rd(8'h04, v); chk("R8 write1 clears", v, sts_e & ~32'h4);
      chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule